// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This block is a purely combinational arithmetic slice for a 32-bit datapath. It treats each operand word as a set of independent lanes, either two 16-bit halves or four 8-bit bytes, and adds or subtracts them lane by lane. It also has two exchange forms that pair each half of the first operand with the opposite half of the second. Every arithmetic operation is available in three result styles: wrapping, clamping and averaging (halving). Each style comes in a signed and an unsigned flavour.

Wrapping operations also produce a four-bit greater-or-equal mask, one bit per byte. A later byte-select operation uses that mask to merge two words. The unit also computes a sum of absolute byte differences, with an optional 32-bit accumulator added in. The surrounding pipeline owns the register file and the flag storage. It feeds the stored mask back on `geIn` and writes `geOut` back when `geWrite` is high.

Top module: `simd_addsub_unit`

## Requirements
- R1: Operation code 0 adds and code 1 subtracts the two 16-bit halves independently (high half in bits 31:16, low half in bits 15:0). With flavour 0 the result wraps modulo 2^16 and no carry passes between halves.
- R2: Operation code 2 gives high = A.high + B.low and low = A.low − B.high. Operation code 3 gives high = A.high − B.low and low = A.low + B.high.
- R3: Operation code 4 adds and code 5 subtracts the four bytes independently, with byte i in bits 8i+7:8i.
- R4: With flavour 1 (clamping), each lane result is limited to the lane's signed range when `isSigned` is 1, and to 0 through the all-ones value when `isSigned` is 0.
- R5: With flavour 2 (halving), each lane result is bits W:1 of the exact (W+1)-bit two's-complement sum or difference. This makes it an arithmetic shift for signed lanes and a logical shift for unsigned lanes.
- R6: For operation codes 0 to 5 with flavour 0, `geWrite` is 1 and `geOut` holds one bit per byte. For a signed lane the bit is 1 when the exact result is zero or positive. For an unsigned add it is 1 on carry out, and for an unsigned subtract it is 1 when there is no borrow. A 16-bit lane drives both bits of its two bytes.
- R7: With flavour 1 or 2, and for operation codes 6 and 7, `geWrite` is 0 and `geOut` equals `geIn`.
- R8: Operation code 6 builds each result byte i from A when `geIn[i]` is 1, and from B otherwise.
- R9: Operation code 7 returns the sum of |A.byte − B.byte| over the four unsigned bytes. When `accEn` is 1 it adds `accIn` modulo 2^32; when `accEn` is 0, `accIn` has no effect.
- R10: Flavour code 3 behaves exactly as flavour 0, including its greater-or-equal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opKind | input | 3 | Operation: 0 add16, 1 sub16, 2 add-high/sub-low exchange, 3 sub-high/add-low exchange, 4 add8, 5 sub8, 6 byte select, 7 absolute-difference sum |
| flavour | input | 2 | Result style: 0 wrap, 1 clamp, 2 halve, 3 treated as wrap |
| isSigned | input | 1 | 1 for signed lanes |
| accEn | input | 1 | Add the accumulator in the difference-sum operation |
| geIn | input | 4 | Stored greater-or-equal mask, bit i for byte i |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| accIn | input | 32 | Accumulator for the difference sum |
| result | output | 32 | Lane-wise result |
| geOut | output | 4 | New mask, or `geIn` when the mask is not written |
| geWrite | output | 1 | High when `geOut` carries a freshly computed mask |

## Verification
The bench builds the unit with its default byte width of 8, which gives the 32-bit word with 16-bit halves. At this width every lane boundary can be reached with hand-picked operands: 0x7F and 0x80 byte edges, 0x7FFF/0x8000 half edges, carries out of the top of each lane, and borrows below zero. The vectors drive clamping at both ends of the range in each signedness. They include halving of negative exact results, where floor rounding matters. They also cover accumulator wrap past 2^32 in the difference sum.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [2:0] {
    OP_ADD16 = 3'd0,
    OP_SUB16 = 3'd1,
    OP_ASX   = 3'd2,
    OP_SAX   = 3'd3,
    OP_ADD8  = 3'd4,
    OP_SUB8  = 3'd5,
    OP_SEL   = 3'd6,
    OP_SAD   = 3'd7
  } opKind_e;

  typedef enum logic [1:0] {
    FL_WRAP = 2'd0,
    FL_SAT  = 2'd1,
    FL_HALF = 2'd2,
    FL_RSVD = 2'd3
  } flavour_e;

  // Strobes from the decoder to the lane datapath
  typedef struct packed {
    logic byteLanes;  // four byte lanes instead of two half lanes
    logic subHi;      // upper lanes subtract
    logic subLo;      // lower lanes subtract
    logic crossB;     // swap the halves of the second operand
    logic doSat;
    logic doHalf;
    logic signedOp;
    logic selOp;
    logic sadOp;
    logic geWrite;
  } ctrl_s;

endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         signedOp,
  input  logic         doSat,
  input  logic         doHalf,
  output logic [W-1:0] res,
  output logic         ge
);

  localparam int XW = W + 2;

  logic signed [XW-1:0] ax, bx, exact;
  logic signed [XW-1:0] sMax, sMin, uMax;

  always_comb begin
    ax    = signedOp ? {{2{a[W-1]}}, a} : {2'b00, a};
    bx    = signedOp ? {{2{b[W-1]}}, b} : {2'b00, b};
    exact = sub ? (ax - bx) : (ax + bx);

    sMax = {3'b000, {(W-1){1'b1}}};
    sMin = {3'b111, {(W-1){1'b0}}};
    uMax = {2'b00, {W{1'b1}}};

    // unsigned add: carry out; everything else: non-negative exact value
    ge = (!signedOp && !sub) ? exact[W] : ~exact[XW-1];

    if (doSat) begin
      if (signedOp) begin
        if (exact > sMax)      res = sMax[W-1:0];
        else if (exact < sMin) res = sMin[W-1:0];
        else                   res = exact[W-1:0];
      end else begin
        if (exact[XW-1])       res = '0;
        else if (exact > uMax) res = uMax[W-1:0];
        else                   res = exact[W-1:0];
      end
    end else if (doHalf) begin
      res = exact[W:1];
    end else begin
      res = exact[W-1:0];
    end
  end

endmodule

// File: rtl/simd_sad.sv
module simd_sad #(
  parameter int BYTE_W = 8,
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES*BYTE_W-1:0] a,
  input  logic [NUM_LANES*BYTE_W-1:0] b,
  input  logic [NUM_LANES*BYTE_W-1:0] acc,
  input  logic                        accEn,
  output logic [NUM_LANES*BYTE_W-1:0] sad
);

  localparam int WORD_W = NUM_LANES * BYTE_W;
  localparam int SUM_W  = BYTE_W + $clog2(NUM_LANES) + 1;

  logic [BYTE_W-1:0] absDiff [NUM_LANES];
  logic [SUM_W-1:0]  sum;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_diff
    logic [BYTE_W-1:0] x, y;
    assign x = a[i*BYTE_W +: BYTE_W];
    assign y = b[i*BYTE_W +: BYTE_W];
    assign absDiff[i] = (x > y) ? (x - y) : (y - x);
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      sum = sum + SUM_W'(absDiff[i]);
    end
    sad = WORD_W'(sum) + (accEn ? acc : '0);
  end

endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  opKind_e  kind,
  input  flavour_e flav,
  input  logic     isSigned,
  output ctrl_s    ctrl
);

  logic arith;

  always_comb begin
    ctrl          = '0;
    arith         = (kind != OP_SEL) && (kind != OP_SAD);
    ctrl.signedOp = isSigned;
    ctrl.doSat    = (flav == FL_SAT);
    ctrl.doHalf   = (flav == FL_HALF);
    unique case (kind)
      OP_ADD16: ;
      OP_SUB16: begin ctrl.subHi = 1'b1; ctrl.subLo = 1'b1; end
      OP_ASX:   begin ctrl.crossB = 1'b1; ctrl.subLo = 1'b1; end
      OP_SAX:   begin ctrl.crossB = 1'b1; ctrl.subHi = 1'b1; end
      OP_ADD8:  ctrl.byteLanes = 1'b1;
      OP_SUB8:  begin ctrl.byteLanes = 1'b1; ctrl.subHi = 1'b1; ctrl.subLo = 1'b1; end
      OP_SEL:   ctrl.selOp = 1'b1;
      OP_SAD:   ctrl.sadOp = 1'b1;
      default: ;
    endcase
    ctrl.geWrite = arith && !ctrl.doSat && !ctrl.doHalf;
  end

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  ctrl_s                ctrl,
  input  logic [4*BYTE_W-1:0]  opA,
  input  logic [4*BYTE_W-1:0]  opB,
  input  logic [4*BYTE_W-1:0]  accIn,
  input  logic                 accEn,
  input  logic [3:0]           geIn,
  output logic [4*BYTE_W-1:0]  result,
  output logic [3:0]           geOut
);

  localparam int NUM_BYTES = 4;
  localparam int NUM_HALVES = 2;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int WORD_W = NUM_BYTES * BYTE_W;

  logic [WORD_W-1:0]     halfRes, byteRes, sadRes, selRes;
  logic [NUM_HALVES-1:0] halfGe;
  logic [NUM_BYTES-1:0]  byteGe;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [HALF_W-1:0] bSel;
    assign bSel = ctrl.crossB ? opB[(NUM_HALVES-1-h)*HALF_W +: HALF_W]
                              : opB[h*HALF_W +: HALF_W];
    simd_lane #(.W(HALF_W)) u_lane (
      .a        (opA[h*HALF_W +: HALF_W]),
      .b        (bSel),
      .sub      ((h == 0) ? ctrl.subLo : ctrl.subHi),
      .signedOp (ctrl.signedOp),
      .doSat    (ctrl.doSat),
      .doHalf   (ctrl.doHalf),
      .res      (halfRes[h*HALF_W +: HALF_W]),
      .ge       (halfGe[h])
    );
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    simd_lane #(.W(BYTE_W)) u_lane (
      .a        (opA[i*BYTE_W +: BYTE_W]),
      .b        (opB[i*BYTE_W +: BYTE_W]),
      .sub      ((i < NUM_BYTES/2) ? ctrl.subLo : ctrl.subHi),
      .signedOp (ctrl.signedOp),
      .doSat    (ctrl.doSat),
      .doHalf   (ctrl.doHalf),
      .res      (byteRes[i*BYTE_W +: BYTE_W]),
      .ge       (byteGe[i])
    );
    assign selRes[i*BYTE_W +: BYTE_W] = geIn[i] ? opA[i*BYTE_W +: BYTE_W]
                                                : opB[i*BYTE_W +: BYTE_W];
  end

  simd_sad #(.BYTE_W(BYTE_W), .NUM_LANES(NUM_BYTES)) u_sad (
    .a     (opA),
    .b     (opB),
    .acc   (accIn),
    .accEn (accEn),
    .sad   (sadRes)
  );

  always_comb begin
    if (ctrl.selOp)          result = selRes;
    else if (ctrl.sadOp)     result = sadRes;
    else if (ctrl.byteLanes) result = byteRes;
    else                     result = halfRes;

    if (!ctrl.geWrite)       geOut = geIn;
    else if (ctrl.byteLanes) geOut = byteGe;
    else                     geOut = {halfGe[1], halfGe[1], halfGe[0], halfGe[0]};
  end

endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
  import simd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [2:0]          opKind,
  input  logic [1:0]          flavour,
  input  logic                isSigned,
  input  logic                accEn,
  input  logic [3:0]          geIn,
  input  logic [4*BYTE_W-1:0] opA,
  input  logic [4*BYTE_W-1:0] opB,
  input  logic [4*BYTE_W-1:0] accIn,
  output logic [4*BYTE_W-1:0] result,
  output logic [3:0]          geOut,
  output logic                geWrite
);

  ctrl_s ctrl;

  simd_ctrl u_ctrl (
    .kind     (opKind_e'(opKind)),
    .flav     (flavour_e'(flavour)),
    .isSigned (isSigned),
    .ctrl     (ctrl)
  );

  simd_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .accIn  (accIn),
    .accEn  (accEn),
    .geIn   (geIn),
    .result (result),
    .geOut  (geOut)
  );

  assign geWrite = ctrl.geWrite;

endmodule

// File: rtl/simd_addsub_checker.sv
module simd_addsub_checker #(
  parameter int BYTE_W = 8
) (
  input logic [2:0]          opKind,
  input logic [1:0]          flavour,
  input logic                isSigned,
  input logic                accEn,
  input logic [3:0]          geIn,
  input logic [4*BYTE_W-1:0] opA,
  input logic [4*BYTE_W-1:0] opB,
  input logic [4*BYTE_W-1:0] result,
  input logic [3:0]          geOut,
  input logic                geWrite
);

  localparam int WORD_W = 4 * BYTE_W;
  localparam logic [WORD_W-1:0] SAD_MAX = WORD_W'(4 * ((1 << BYTE_W) - 1));

  always_comb begin
    if (flavour == 2'd1 || flavour == 2'd2 || opKind >= 3'd6) begin
      assert_ge_hold_R7: assert (!geWrite && geOut == geIn)
        else $error("mask changed by a non-wrapping operation");
    end
    if (opKind <= 3'd3 && geWrite) begin
      assert_ge_pairs_R6: assert (geOut[3] == geOut[2] && geOut[1] == geOut[0])
        else $error("half lane mask bits differ");
    end
    if (flavour == 2'd3 && opKind < 3'd6) begin
      assert_rsvd_wraps_R10: assert (geWrite)
        else $error("flavour 3 did not write the mask");
    end
    if (opKind == 3'd7 && !accEn) begin
      assert_sad_bound_R9: assert (result <= SAD_MAX)
        else $error("difference sum out of range");
    end
    for (int i = 0; i < 4; i++) begin
      if (opKind == 3'd6) begin
        assert_sel_byte_R8: assert (result[i*BYTE_W +: BYTE_W] ==
            (geIn[i] ? opA[i*BYTE_W +: BYTE_W] : opB[i*BYTE_W +: BYTE_W]))
          else $error("select byte mismatch");
      end
      if (opKind == 3'd4 && flavour == 2'd1 && !isSigned) begin
        assert_usat_floor_R4: assert (result[i*BYTE_W +: BYTE_W] >= opA[i*BYTE_W +: BYTE_W] &&
                                      result[i*BYTE_W +: BYTE_W] >= opB[i*BYTE_W +: BYTE_W])
          else $error("clamped unsigned byte sum below an operand");
      end
    end
  end

endmodule

bind simd_addsub_unit simd_addsub_checker #(.BYTE_W(BYTE_W)) u_chk (
  .opKind   (opKind),
  .flavour  (flavour),
  .isSigned (isSigned),
  .accEn    (accEn),
  .geIn     (geIn),
  .opA      (opA),
  .opB      (opB),
  .result   (result),
  .geOut    (geOut),
  .geWrite  (geWrite)
);

// File: tb/simd_addsub_unit_test.sv
module simd_addsub_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  typedef struct packed {
    logic [2:0]  kind;
    logic [1:0]  flav;
    logic        sgn;
    logic        accE;
    logic [3:0]  gIn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] acc;
    logic [31:0] expRes;
    logic [3:0]  expGe;
    logic        expWr;
    logic [3:0]  req;
  } vec_t;

  localparam int NUM_VEC = 20;
  localparam vec_t VECS [NUM_VEC] = '{
    // R1 unsigned half add, carries out of both halves
    '{3'd0, 2'd0, 1'b0, 1'b0, 4'b0000, 32'h80000001, 32'h8000FFFF, 32'h0, 32'h00000000, 4'b1111, 1'b1, 4'd1},
    // R6 signed half add, exact high result positive, low negative
    '{3'd0, 2'd0, 1'b1, 1'b0, 4'b0000, 32'h7FFFFFFF, 32'h0001FFFF, 32'h0, 32'h8000FFFE, 4'b1100, 1'b1, 4'd6},
    // R1 unsigned half subtract, borrow in low half only
    '{3'd1, 2'd0, 1'b0, 1'b0, 4'b1111, 32'h00050003, 32'h00030005, 32'h0, 32'h0002FFFE, 4'b1100, 1'b1, 4'd1},
    // R2 add-high/sub-low exchange
    '{3'd2, 2'd0, 1'b1, 1'b0, 4'b0000, 32'h00100020, 32'h00030004, 32'h0, 32'h0014001D, 4'b1111, 1'b1, 4'd2},
    // R2 sub-high/add-low exchange with negative high
    '{3'd3, 2'd0, 1'b1, 1'b0, 4'b1111, 32'h00100020, 32'h00030014, 32'h0, 32'hFFFC0023, 4'b0011, 1'b1, 4'd2},
    // R3 unsigned byte add
    '{3'd4, 2'd0, 1'b0, 1'b0, 4'b0000, 32'hFF800110, 32'h0180FE10, 32'h0, 32'h0000FF20, 4'b1100, 1'b1, 4'd3},
    // R3 signed byte subtract with wrap both ways
    '{3'd5, 2'd0, 1'b1, 1'b0, 4'b0000, 32'h807F0005, 32'h01FF0105, 32'h0, 32'h7F80FF00, 4'b0101, 1'b1, 4'd3},
    // R4 signed clamped byte add, both limits
    '{3'd4, 2'd1, 1'b1, 1'b0, 4'b1010, 32'h7F8010F0, 32'h01FF20F0, 32'h0, 32'h7F8030E0, 4'b1010, 1'b0, 4'd4},
    // R4 unsigned clamped half subtract at zero
    '{3'd1, 2'd1, 1'b0, 1'b0, 4'b0110, 32'h0005FFFF, 32'h00060001, 32'h0, 32'h0000FFFE, 4'b0110, 1'b0, 4'd4},
    // R4 unsigned clamped half add at all-ones
    '{3'd0, 2'd1, 1'b0, 1'b0, 4'b0001, 32'hFFF01234, 32'h00200001, 32'h0, 32'hFFFF1235, 4'b0001, 1'b0, 4'd4},
    // R5 unsigned halving byte add
    '{3'd4, 2'd2, 1'b0, 1'b0, 4'b1111, 32'hFF018003, 32'hFF028000, 32'h0, 32'hFF018001, 4'b1111, 1'b0, 4'd5},
    // R5 signed halving half subtract, floor rounding
    '{3'd1, 2'd2, 1'b1, 1'b0, 4'b1001, 32'h80000001, 32'h7FFF0004, 32'h0, 32'h8000FFFE, 4'b1001, 1'b0, 4'd5},
    // R5 unsigned halving byte subtract below zero
    '{3'd5, 2'd2, 1'b0, 1'b0, 4'b0000, 32'h00100000, 32'h01000000, 32'h0, 32'hFF080000, 4'b0000, 1'b0, 4'd5},
    // R8 byte select by mask
    '{3'd6, 2'd0, 1'b0, 1'b0, 4'b0101, 32'h11223344, 32'hAABBCCDD, 32'h0, 32'hAA22CC44, 4'b0101, 1'b0, 4'd8},
    // R9 difference sum, accumulator disabled
    '{3'd7, 2'd0, 1'b0, 1'b0, 4'b0011, 32'h00FF1005, 32'hFF001510, 32'h12345678, 32'h0000020E, 4'b0011, 1'b0, 4'd9},
    // R9 difference sum plus accumulator
    '{3'd7, 2'd0, 1'b0, 1'b1, 4'b0011, 32'h00FF1005, 32'hFF001510, 32'h00001000, 32'h0000120E, 4'b0011, 1'b0, 4'd9},
    // R9 accumulator wraps past 2^32
    '{3'd7, 2'd0, 1'b0, 1'b1, 4'b0000, 32'h00FF1005, 32'hFF001510, 32'hFFFFFE00, 32'h0000000E, 4'b0000, 1'b0, 4'd9},
    // R10 flavour 3 matches the wrapping add of the first vector
    '{3'd0, 2'd3, 1'b0, 1'b0, 4'b0000, 32'h80000001, 32'h8000FFFF, 32'h0, 32'h00000000, 4'b1111, 1'b1, 4'd10},
    // R4 signed clamped exchange, R7 mask held
    '{3'd2, 2'd1, 1'b1, 1'b0, 4'b0011, 32'h7FFF8000, 32'h00010001, 32'h0, 32'h7FFF8000, 4'b0011, 1'b0, 4'd4},
    // R5 unsigned halving sub-high/add-low exchange
    '{3'd3, 2'd2, 1'b0, 1'b0, 4'b0000, 32'h00030001, 32'h00010005, 32'h0, 32'hFFFF0001, 4'b0000, 1'b0, 4'd5}
  };

  logic        clk = 1'b0;
  logic [2:0]  opKind;
  logic [1:0]  flavour;
  logic        isSigned, accEn;
  logic [3:0]  geIn;
  logic [31:0] opA, opB, accIn;
  logic [31:0] result;
  logic [3:0]  geOut;
  logic        geWrite;

  int applied = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_addsub_unit #(.BYTE_W(8)) uut (
    .opKind(opKind), .flavour(flavour), .isSigned(isSigned), .accEn(accEn),
    .geIn(geIn), .opA(opA), .opB(opB), .accIn(accIn),
    .result(result), .geOut(geOut), .geWrite(geWrite)
  );

  task automatic applyVec(input vec_t v);
    @(negedge clk);
    opKind = v.kind; flavour = v.flav; isSigned = v.sgn; accEn = v.accE;
    geIn = v.gIn; opA = v.a; opB = v.b; accIn = v.acc;
    #(CLK_PERIOD/4);
    applied++;
    if (result !== v.expRes || geOut !== v.expGe || geWrite !== v.expWr) begin
      miscompares++;
      $display("FAIL R%0d: result=%h ge=%b wr=%b expected result=%h ge=%b wr=%b",
               v.req, result, geOut, geWrite, v.expRes, v.expGe, v.expWr);
    end
  endtask

  initial begin
    opKind = '0; flavour = '0; isSigned = 1'b0; accEn = 1'b0;
    geIn = '0; opA = '0; opB = '0; accIn = '0;

    // Idle state: zero operands through unsigned wrapping add (R1, R6)
    applyVec('{3'd0, 2'd0, 1'b0, 1'b0, 4'b0000, 32'h0, 32'h0, 32'h0, 32'h0, 4'b0000, 1'b1, 4'd1});

    for (int i = 0; i < NUM_VEC; i++) begin
      applyVec(VECS[i]);
    end

    // R8 corners: full mask picks A, empty mask picks B
    applyVec('{3'd6, 2'd0, 1'b0, 1'b0, 4'b1111, 32'h01234567, 32'h89ABCDEF, 32'h0, 32'h01234567, 4'b1111, 1'b0, 4'd8});
    applyVec('{3'd6, 2'd0, 1'b0, 1'b0, 4'b0000, 32'h01234567, 32'h89ABCDEF, 32'h0, 32'h89ABCDEF, 4'b0000, 1'b0, 4'd8});
    // R9: accumulator value ignored when disabled
    applyVec('{3'd7, 2'd0, 1'b0, 1'b0, 4'b0000, 32'h00FF1005, 32'hFF001510, 32'hFFFFFFFF, 32'h0000020E, 4'b0000, 1'b0, 4'd9});
    // R10 flavour 3 on signed byte subtract equals wrapping form
    applyVec('{3'd5, 2'd3, 1'b1, 1'b0, 4'b1111, 32'h807F0005, 32'h01FF0105, 32'h0, 32'h7F80FF00, 4'b0101, 1'b1, 4'd10});
    // R7 signed halving half add leaves a nonzero mask intact
    applyVec('{3'd0, 2'd2, 1'b1, 1'b0, 4'b1011, 32'h7FFF8000, 32'h7FFF8000, 32'h0, 32'h7FFF8000, 4'b1011, 1'b0, 4'd7});

    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion within %0d cycles", WATCHDOG_CYCLES);
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule